// File: doc/BRIEF.md
# Region-indexed protection register bank

This block keeps the per-region configuration words of a memory protection unit whose region count is set by a parameter. Each region owns three 32-bit words: a base address word, a size/enable word and an access-control word. Software never addresses a region directly. It first writes a region-number register and then reads or writes one of the three region words through a small register port. The port has a 2-bit select, a separate select for a read-only type register, a single-cycle write enable and combinational read data.

Every region's three words are also driven out in parallel on flat buses so that an address-lookup unit can compare against all regions at once. Any write that changes a region word raises a one-cycle invalidate pulse. The lookup side uses that pulse to drop cached permission results that may now be stale. The type register reports how many regions exist, so software can size its loops.

Top module: `mpu_region_bank`

## Requirements
- R1: After reset every word of all three region arrays is zero, the region-number register is zero and `invalidate` is low.
- R2: With `type_sel` low, `reg_sel` selects a register: 0 is the base word, 1 is the size/enable word, 2 is the access-control word and 3 is the region number. Reads and writes of the three region words act only on the entry named by the current region number. Other entries keep their values.
- R3: A write to the region number (`reg_sel`=3) with a value below `NUM_REGIONS` is taken. After that write, reading the number returns the value, zero-extended.
- R4: A write to the region number with a value greater than or equal to `NUM_REGIONS` is ignored, and the previous number stays.
- R5: A write to a region word makes `invalidate` high for exactly the one cycle that follows the write edge. Writes to the region number or the type register do not pulse it.
- R6: With `type_sel` high, `rd_data` returns `NUM_REGIONS` shifted left by 8, with all other bits zero (0x0000_1000 for 16 regions). A write while `type_sel` is high changes no state and raises no pulse.
- R7: On `base_words`, `size_words` and `acc_words`, region i sits at bits [32*i+31 : 32*i]. These buses reflect a write from the cycle after its write edge.
- R8: With `NUM_REGIONS` = 0, every read returns zero, writes have no effect and `invalidate` stays low. `NUM_REGIONS` must not exceed 255.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| reg_sel | input | 2 | Register select: 0 base, 1 size, 2 access, 3 number |
| type_sel | input | 1 | Selects the read-only type register; overrides reg_sel |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for the selected register |
| base_words | output | 32*max(NUM_REGIONS,1) | All base words, region i at word i |
| size_words | output | 32*max(NUM_REGIONS,1) | All size/enable words, region i at word i |
| acc_words | output | 32*max(NUM_REGIONS,1) | All access-control words, region i at word i |
| invalidate | output | 1 | One-cycle pulse after any region word write |

## Verification
The assertions assume that `wr_en` is low while reset is held, so the first cycle after release carries no write left over from the reset phase. They also assume `reg_sel` and `type_sel` are stable across each clock edge. The stimulus changes every input only on the falling edge and keeps the write strobe low during both resets. Region-number writes include values at the count and far above it, so the assertion that the index stays in range is tested against the real rejection path.

// File: rtl/mpu_bank_pkg.sv
package mpu_bank_pkg;

    localparam int unsigned WORD_W     = 32;
    localparam int unsigned TYPE_SHIFT = 8;
    localparam int unsigned MAX_REGION = 255;

    typedef enum logic [1:0] {
        RSEL_BASE   = 2'd0,
        RSEL_SIZE   = 2'd1,
        RSEL_ACCESS = 2'd2,
        RSEL_NUMBER = 2'd3
    } rsel_e;

endpackage

// File: rtl/mpu_region_index.sv
module mpu_region_index #(
    parameter int unsigned NR    = 16,
    parameter int unsigned IDX_W = 4,
    parameter int unsigned W     = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             num_we,
    input  logic             region_we,
    input  logic [W-1:0]     wdata,
    output logic [IDX_W-1:0] idx,
    output logic             inval
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             inval;
    } idx_st_t;

    idx_st_t st_d, st_q;
    logic    in_range;

    assign in_range = (NR > 0) && (wdata < W'(NR));

    always_comb begin
        st_d       = st_q;
        st_d.inval = region_we;
        if (num_we && in_range) begin
            st_d.idx = wdata[IDX_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idx   = st_q.idx;
    assign inval = st_q.inval;
endmodule

// File: rtl/mpu_region_array.sv
module mpu_region_array #(
    parameter int unsigned NR    = 16,
    parameter int unsigned W     = 32,
    parameter int unsigned IDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [W-1:0]      wdata,
    output logic [NR*W-1:0]   words
);
    typedef struct packed {
        logic [NR-1:0][W-1:0] ent;
    } arr_st_t;

    arr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.ent[idx] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar i = 0; i < NR; i++) begin : g_out
        assign words[i*W +: W] = st_q.ent[i];
    end
endmodule

// File: rtl/mpu_read_mux.sv
module mpu_read_mux
    import mpu_bank_pkg::*;
#(
    parameter int unsigned NUM_REGIONS = 16,
    parameter int unsigned NR_EFF      = 16,
    parameter int unsigned W           = 32,
    parameter int unsigned IDX_W       = 4
) (
    input  logic [1:0]          sel,
    input  logic                type_sel,
    input  logic [IDX_W-1:0]    idx,
    input  logic [NR_EFF*W-1:0] base_words,
    input  logic [NR_EFF*W-1:0] size_words,
    input  logic [NR_EFF*W-1:0] acc_words,
    output logic [W-1:0]        rd_data
);
    localparam logic [W-1:0] TYPE_WORD = W'(NUM_REGIONS) << TYPE_SHIFT;

    logic [31:0] ofs;
    rsel_e       rsel;

    assign ofs  = 32'(idx) * 32'(W);
    assign rsel = rsel_e'(sel);

    always_comb begin
        rd_data = '0;
        if (type_sel) begin
            rd_data = TYPE_WORD;
        end else if (NUM_REGIONS > 0) begin
            unique case (rsel)
                RSEL_BASE:   rd_data = base_words[ofs +: W];
                RSEL_SIZE:   rd_data = size_words[ofs +: W];
                RSEL_ACCESS: rd_data = acc_words[ofs +: W];
                RSEL_NUMBER: rd_data = W'(idx);
                default:     rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/mpu_region_bank.sv
module mpu_region_bank
    import mpu_bank_pkg::*;
#(
    parameter int unsigned NUM_REGIONS = 16,
    localparam int unsigned W          = WORD_W,
    localparam int unsigned NR_EFF     = (NUM_REGIONS == 0) ? 1 : NUM_REGIONS,
    localparam int unsigned IDX_W      = (NR_EFF > 1) ? $clog2(NR_EFF) : 1,
    localparam int unsigned FLAT_W     = NR_EFF * W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        reg_sel,
    input  logic              type_sel,
    input  logic [W-1:0]      wr_data,
    output logic [W-1:0]      rd_data,
    output logic [FLAT_W-1:0] base_words,
    output logic [FLAT_W-1:0] size_words,
    output logic [FLAT_W-1:0] acc_words,
    output logic              invalidate
);
    if (NUM_REGIONS > MAX_REGION) begin : g_bad_count
        $error("NUM_REGIONS above supported maximum");
    end

    logic             port_we;
    logic             num_we;
    logic             region_we;
    logic [IDX_W-1:0] cur_idx;
    logic [FLAT_W-1:0] arr_words [3];

    assign port_we   = wr_en && !type_sel;
    assign num_we    = port_we && (reg_sel == RSEL_NUMBER);
    assign region_we = port_we && (reg_sel != RSEL_NUMBER) && (NUM_REGIONS > 0);

    mpu_region_index #(
        .NR    (NUM_REGIONS),
        .IDX_W (IDX_W),
        .W     (W)
    ) u_index (
        .clk       (clk),
        .rst_n     (rst_n),
        .num_we    (num_we),
        .region_we (region_we),
        .wdata     (wr_data),
        .idx       (cur_idx),
        .inval     (invalidate)
    );

    for (genvar k = 0; k < 3; k++) begin : g_arr
        logic arr_we;
        assign arr_we = region_we && (reg_sel == 2'(k));
        mpu_region_array #(
            .NR    (NR_EFF),
            .W     (W),
            .IDX_W (IDX_W)
        ) u_arr (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (arr_we),
            .idx   (cur_idx),
            .wdata (wr_data),
            .words (arr_words[k])
        );
    end

    assign base_words = arr_words[0];
    assign size_words = arr_words[1];
    assign acc_words  = arr_words[2];

    mpu_read_mux #(
        .NUM_REGIONS (NUM_REGIONS),
        .NR_EFF      (NR_EFF),
        .W           (W),
        .IDX_W       (IDX_W)
    ) u_rmux (
        .sel        (reg_sel),
        .type_sel   (type_sel),
        .idx        (cur_idx),
        .base_words (base_words),
        .size_words (size_words),
        .acc_words  (acc_words),
        .rd_data    (rd_data)
    );
endmodule

// File: rtl/mpu_bank_chk.sv
module mpu_bank_chk #(
    parameter int unsigned NR    = 16,
    parameter int unsigned IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       reg_sel,
    input logic             type_sel,
    input logic [31:0]      wr_data,
    input logic [31:0]      rd_data,
    input logic             invalidate,
    input logic [IDX_W-1:0] cur_idx
);
    logic wr_region;
    logic wr_number;

    assign wr_region = wr_en && !type_sel && (reg_sel != 2'd3) && (NR > 0);
    assign wr_number = wr_en && !type_sel && (reg_sel == 2'd3);

    if (NR > 0) begin : g_range
        assert_idx_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
            32'(cur_idx) < NR);
    end

    assert_num_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_number && (wr_data >= 32'(NR))) |=> $stable(cur_idx));

    assert_num_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_number && (wr_data < 32'(NR))) |=> (32'(cur_idx) == $past(wr_data)));

    assert_inval_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_region |=> invalidate);

    assert_inval_has_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        invalidate |-> $past(wr_region));

    assert_type_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
        type_sel |-> (rd_data == (32'(NR) << 8)));

    assert_type_write_inert_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && type_sel) |=> ($stable(cur_idx) && !invalidate));
endmodule

bind mpu_region_bank mpu_bank_chk #(
    .NR    (NUM_REGIONS),
    .IDX_W (IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .reg_sel    (reg_sel),
    .type_sel   (type_sel),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .invalidate (invalidate),
    .cur_idx    (cur_idx)
);

// File: tb/sim_mpu_region_bank.sv
module sim_mpu_region_bank;
    localparam int NR = 16;

    localparam int K_RD   = 0;
    localparam int K_INV  = 1;
    localparam int K_EXP  = 2;
    localparam int K_RD1  = 5;
    localparam int K_INV1 = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic        type_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data, rd_data1;
    logic [NR*32-1:0] base_w, size_w, acc_w;
    logic [31:0] base1, size1, acc1;
    logic        inval, inval1;

    always #2.5 clk = ~clk;

    mpu_region_bank #(.NUM_REGIONS(NR)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
        .type_sel(type_sel), .wr_data(wr_data), .rd_data(rd_data),
        .base_words(base_w), .size_words(size_w), .acc_words(acc_w),
        .invalidate(inval));

    // R8: zero-region instance fed the same stimulus
    mpu_region_bank #(.NUM_REGIONS(0)) u1 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
        .type_sel(type_sel), .wr_data(wr_data), .rd_data(rd_data1),
        .base_words(base1), .size_words(size1), .acc_words(acc1),
        .invalidate(inval1));

    typedef struct {
        int          req;
        int          kind;
        int          idx;
        logic [31:0] exp;
    } item_t;

    item_t q[$];
    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [31:0] m_arr [3][NR];
    int          m_idx;

    function automatic void push(int req, int kind, int idx, logic [31:0] exp);
        item_t it;
        it.req = req; it.kind = kind; it.idx = idx; it.exp = exp;
        q.push_back(it);
    endfunction

    function automatic void model_clear();
        for (int k = 0; k < 3; k++)
            for (int i = 0; i < NR; i++) m_arr[k][i] = '0;
        m_idx = 0;
    endfunction

    // monitor: scoreboard pops items queued for this cycle
    always @(posedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            case (it.kind)
                K_RD:   act = rd_data;
                K_INV:  act = {31'b0, inval};
                K_EXP:  act = base_w[it.idx*32 +: 32];
                3:      act = size_w[it.idx*32 +: 32];
                4:      act = acc_w[it.idx*32 +: 32];
                K_RD1:  act = rd_data1;
                default: act = {31'b0, inval1};
            endcase
            n_tests++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL R%0d kind %0d idx %0d: actual %h expected %h",
                         it.req, it.kind, it.idx, act, it.exp);
            end
        end
    end

    task automatic set_in(input logic we, input logic [1:0] sel,
                          input logic ts, input logic [31:0] d);
        @(negedge clk);
        wr_en = we; reg_sel = sel; type_sel = ts; wr_data = d;
    endtask

    // read cycle; invalidate must be low (R5 pulse length, R8 zero instance)
    task automatic rd(input int req, input logic [1:0] sel, input logic [31:0] exp);
        set_in(1'b0, sel, 1'b0, '0);
        push(req, K_RD, 0, exp);
        push(5, K_INV, 0, 32'd0);
        push(8, K_RD1, 0, 32'd0);
        push(8, K_INV1, 0, 32'd0);
        @(posedge clk);
    endtask

    task automatic rd_type();
        set_in(1'b0, 2'd0, 1'b1, '0);
        push(6, K_RD, 0, 32'(NR) << 8);
        push(8, K_RD1, 0, 32'd0);
        @(posedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d, input logic ts);
        logic pulse;
        set_in(1'b1, sel, ts, d);
        pulse = 1'b0;
        if (!ts) begin
            if (sel == 2'd3) begin
                if (d < 32'(NR)) m_idx = int'(d);
            end else begin
                m_arr[sel][m_idx] = d;
                pulse = 1'b1;
            end
        end
        @(posedge clk);
        set_in(1'b0, 2'd0, 1'b0, '0);
        push(5, K_INV, 0, {31'b0, pulse});
        push(8, K_INV1, 0, 32'd0);
        @(posedge clk);
    endtask

    task automatic check_region(input int req, input int i);
        set_in(1'b0, 2'd0, 1'b0, '0);
        push(req, K_EXP, i, m_arr[0][i]);
        push(req, 3, i, m_arr[1][i]);
        push(req, 4, i, m_arr[2][i]);
        @(posedge clk);
    endtask

    task automatic rd_all_current(input int req);
        rd(req, 2'd0, m_arr[0][m_idx]);
        rd(req, 2'd1, m_arr[1][m_idx]);
        rd(req, 2'd2, m_arr[2][m_idx]);
        rd(3, 2'd3, 32'(m_idx));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_clear();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        rd_all_current(1);
        for (int i = 0; i < NR; i++) check_region(1, i);
        rd_type(); // R6

        // R3: accepted number write, no pulse (R5)
        wr(2'd3, 32'd5, 1'b0);
        rd(3, 2'd3, 32'd5);

        // R2 / R5 / R7: region words at index 5
        wr(2'd0, 32'h2000_0000, 1'b0);
        wr(2'd1, 32'h0000_0023, 1'b0);
        wr(2'd2, 32'h0000_1300, 1'b0);
        rd_all_current(2);
        check_region(7, 5);
        check_region(2, 4);
        check_region(2, 6);

        // R4: out-of-range number writes
        wr(2'd3, 32'd16, 1'b0);
        rd(4, 2'd3, 32'd5);
        wr(2'd3, 32'hFFFF_FFFF, 1'b0);
        rd(4, 2'd3, 32'd5);
        wr(2'd3, 32'h0000_0105, 1'b0);
        rd(4, 2'd3, 32'd5);

        // R3 boundary: last valid index
        wr(2'd3, 32'd15, 1'b0);
        rd(3, 2'd3, 32'd15);
        wr(2'd0, 32'hFFFF_FFE0, 1'b0);
        rd_all_current(2);
        check_region(7, 15);

        // R6: type register write is inert
        wr(2'd3, 32'd3, 1'b1);
        rd_type();
        rd(6, 2'd3, 32'd15);

        // R2 / R7: distinct pattern in every region, then read back
        for (int i = 0; i < NR; i++) begin
            wr(2'd3, 32'(i), 1'b0);
            wr(2'd0, 32'h1000_0000 + 32'(i) * 32'h100, 1'b0);
            wr(2'd1, 32'(i * 2 + 1), 1'b0);
            wr(2'd2, 32'hA5A5_0000 ^ 32'(i), 1'b0);
        end
        for (int i = NR - 1; i >= 0; i--) begin
            wr(2'd3, 32'(i), 1'b0);
            rd_all_current(2);
        end
        for (int i = 0; i < NR; i++) check_region(7, i);

        // R1: reset during operation clears everything
        do_reset();
        rd_all_current(1);
        for (int i = 0; i < NR; i++) check_region(1, i);
        rd_type();

        repeat (3) @(posedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule